// File: doc/BRIEF.md
# Frame preemption verification controller

This block is the per-port control and status logic of a MAC merge (frame preemption) layer. Configuration and status go through a small register port. Software turns on transmit-side and receive-side merge and sets a verify timeout in milliseconds. The block then runs the verification handshake. It asks the MAC to send a verify request, waits for the response strobe, and retries on each timeout. The outcome is shown as an encoded verify state.

Preemption becomes active once verification has succeeded, or when verification is bypassed while transmit merge is on. Each change of the active flag is latched in a sticky status bit. So is every preemptible frame that arrives, or is requested for transmission, at a moment when preemption is not allowed. A level interrupt stays high while any sticky bit is set. Sticky bits are cleared by writing one to them.

The block also drives the preemptible traffic-class mask to the queue system. This mask is forced to zero unless preemption is active and the link mode permits preemption. It also publishes the minimum fragment sizes for transmit and receive.

Top module: `fp_verify_ctrl`

## Requirements
- R1: After reset the verify state code reads 0 (INITIAL), `irq` is low, `commit_tcs` is zero and both merge enables are low.
- R2: The verify state code (status register, address 3, bits [2:0]) is one of INITIAL=0, VERIFYING=1, SUCCEEDED=2, FAILED=3, DISABLED=4. Codes 5 to 7 never appear.
- R3: Transmit merge is enabled with address 0 bit 0. When it is set and the verify-disable bit is clear, the state goes INITIAL then VERIFYING. `send_verify` pulses once on entry and once at each timeout, for exactly 3 pulses. The state reaches FAILED exactly 3·T·CLKS_PER_MS cycles after entering VERIFYING, where T is the effective timeout.
- R4: The verify time field (address 1, bits [15:8], in ms) is used as 1 when written as 0, and as 128 when written above 128.
- R5: A `rsp_rx` strobe in VERIFYING moves the state to SUCCEEDED. Preemption becomes active (status bit 4).
- R6: The verify-disable bit (address 1, bit 0) forces the state to DISABLED. In that state preemption is active exactly while transmit merge is enabled.
- R7: Status bit 5 sets whenever the active flag changes. Clearing transmit merge drops active to 0 and so raises `irq`.
- R8: Status bit 6 sets when `pfrm_rx` pulses while the state is not SUCCEEDED. It stays clear otherwise.
- R9: Status bit 7 sets when `pfrm_tx_req` pulses while preemption is not active. It stays clear otherwise.
- R10: Writing one to status bits [7:5] clears them, and writing zero leaves them. A set event in the same cycle as a clear wins. `irq` is high exactly while any of bits [7:5] is set.
- R11: `commit_tcs` equals the mask in address 2, bits [NUM_TC-1:0], when preemption is active and either `link_qsgmii` is low or `link_gig` is high. Otherwise it is zero.
- R12: `tx_min_frag` equals 64·(1+k)−4 for the 2-bit field k in address 2, bits [17:16], giving 60, 124, 188 or 252. `rx_min_frag` is 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (read and write) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| rsp_rx | input | 1 | Verify response received strobe from MAC |
| pfrm_rx | input | 1 | Preemptible frame received strobe |
| pfrm_tx_req | input | 1 | Preemptible frame transmit request strobe |
| link_gig | input | 1 | Link runs at gigabit speed |
| link_qsgmii | input | 1 | Link uses quad-serial gigabit mode |
| tx_merge_en | output | 1 | Transmit merge enable to MAC |
| rx_merge_en | output | 1 | Receive merge enable to MAC |
| send_verify | output | 1 | One-cycle request to send a verify frame |
| commit_tcs | output | NUM_TC | Committed preemptible traffic-class mask |
| tx_min_frag | output | 8 | Minimum transmit fragment size in bytes |
| rx_min_frag | output | 8 | Minimum receive fragment size in bytes |
| irq | output | 1 | Interrupt, high while any sticky bit is set |

## Verification
Two functions can land in the same cycle: a software write-one-to-clear of a sticky bit, and the hardware event that sets that same bit. The bench provokes this by holding `pfrm_rx` high in the exact cycle of the clear write while the state is INITIAL. It then expects bit 6 to read back still set, and `irq` to remain high. A plain clear in a later cycle must then drop the bit. Timeouts are judged to the exact cycle by counting clocks from the first VERIFYING read.

// File: rtl/fpv_pkg.sv
package fpv_pkg;

   typedef enum logic [2:0] {
      VS_INIT      = 3'd0,
      VS_VERIFYING = 3'd1,
      VS_OK        = 3'd2,
      VS_FAIL      = 3'd3,
      VS_OFF       = 3'd4
   } vstate_e;

   localparam int EV_ACT = 0;
   localparam int EV_RX  = 1;
   localparam int EV_TX  = 2;
   localparam int NUM_EV = 3;

   localparam int RX_MIN_FRAG = 60;

   function automatic logic [7:0] tx_frag_bytes(input logic [1:0] k);
      return 8'(64 * (32'(k) + 1) - 4);
   endfunction

endpackage

// File: rtl/fpv_verify_fsm.sv
module fpv_verify_fsm
   import fpv_pkg::*;
#(
   parameter int CLKS_PER_MS  = 125000,
   parameter int MS_W         = 8,
   parameter int VERIFY_TRIES = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tx_en,
   input  logic            verify_dis,
   input  logic [MS_W-1:0] vt_ms,
   input  logic            rsp_rx,
   output vstate_e         state_o,
   output logic            send_verify
);

   localparam int PRE_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
   localparam int TRY_W = $clog2(VERIFY_TRIES + 1);
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_MS - 1);

   generate
      if (CLKS_PER_MS < 1)  begin : g_bad_clk  $error("CLKS_PER_MS must be positive"); end
      if (VERIFY_TRIES < 1) begin : g_bad_try  $error("VERIFY_TRIES must be positive"); end
   endgenerate

   vstate_e          state_q, nxt;
   logic [PRE_W-1:0] pre_q;
   logic [MS_W-1:0]  ms_q;
   logic [TRY_W-1:0] tries_q;
   logic             start, retry, expire, send_q;

   assign expire = (pre_q == PRE_LAST) && (ms_q == vt_ms - 1'b1);

   always_comb begin
      nxt   = state_q;
      start = 1'b0;
      retry = 1'b0;
      if (verify_dis) begin
         nxt = VS_OFF;
      end else if (!tx_en) begin
         nxt = VS_INIT;
      end else begin
         case (state_q)
            VS_INIT: begin
               nxt   = VS_VERIFYING;
               start = 1'b1;
            end
            VS_OFF: nxt = VS_INIT;
            VS_VERIFYING: begin
               if (rsp_rx) begin
                  nxt = VS_OK;
               end else if (expire) begin
                  if (tries_q == TRY_W'(VERIFY_TRIES)) nxt = VS_FAIL;
                  else retry = 1'b1;
               end
            end
            default: nxt = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= VS_INIT;
         pre_q   <= '0;
         ms_q    <= '0;
         tries_q <= '0;
         send_q  <= 1'b0;
      end else begin
         state_q <= nxt;
         send_q  <= start | retry;
         if (start)      tries_q <= TRY_W'(1);
         else if (retry) tries_q <= tries_q + 1'b1;
         if (start || retry || state_q != VS_VERIFYING) begin
            pre_q <= '0;
            ms_q  <= '0;
         end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            ms_q  <= ms_q + 1'b1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   assign state_o     = state_q;
   assign send_verify = send_q;

   // R3: a verify request only goes out while the handshake is running
   a_r3_send_in_verify: assert property (@(posedge clk) disable iff (!rst_n)
      send_q |-> state_q == VS_VERIFYING);

   // R3: never more requests than the retry budget
   a_r3_try_budget: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q <= TRY_W'(VERIFY_TRIES));

   // R5: a response during the handshake always leads to success
   a_r5_rsp_success: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == VS_VERIFYING && rsp_rx && tx_en && !verify_dis) |=> state_q == VS_OK);

endmodule

// File: rtl/fpv_sticky_bank.sv
module fpv_sticky_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] sticky_o,
   output logic         irq_o
);

   generate
      if (N < 1) begin : g_bad_n  $error("sticky bank needs at least one bit"); end
   endgenerate

   logic [N-1:0] sticky_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         sticky_q[i] <= 1'b0;
         else if (set_i[i])  sticky_q[i] <= 1'b1;
         else if (clr_i[i])  sticky_q[i] <= 1'b0;
      end

      // R10: a set event wins over a clear in the same cycle
      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> sticky_q[i]);

      // R10: a bit without a set event but with a clear goes low
      a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !sticky_q[i]);
   end

   assign sticky_o = sticky_q;
   assign irq_o    = |sticky_q;

endmodule

// File: rtl/fpv_tc_gate.sv
module fpv_tc_gate #(
   parameter int NUM_TC    = 8,
   parameter bit LINK_GATE = 1'b1
) (
   input  logic              active,
   input  logic              link_qsgmii,
   input  logic              link_gig,
   input  logic [NUM_TC-1:0] cfg_mask,
   output logic [NUM_TC-1:0] commit_mask
);

   logic link_ok;

   generate
      if (LINK_GATE) begin : g_link_gate
         assign link_ok = !link_qsgmii || link_gig;
      end else begin : g_no_gate
         logic unused_link;
         assign unused_link = link_qsgmii ^ link_gig;
         assign link_ok     = 1'b1;
      end
   endgenerate

   assign commit_mask = (active && link_ok) ? cfg_mask : '0;

endmodule

// File: rtl/fp_verify_ctrl.sv
module fp_verify_ctrl
   import fpv_pkg::*;
#(
   parameter int NUM_TC        = 8,
   parameter int CLKS_PER_MS   = 125000,
   parameter int MAX_VERIFY_MS = 128,
   parameter int VERIFY_TRIES  = 3,
   parameter int VT_RESET      = 10,
   parameter bit LINK_GATE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              rsp_rx,
   input  logic              pfrm_rx,
   input  logic              pfrm_tx_req,
   input  logic              link_gig,
   input  logic              link_qsgmii,
   output logic              tx_merge_en,
   output logic              rx_merge_en,
   output logic              send_verify,
   output logic [NUM_TC-1:0] commit_tcs,
   output logic [7:0]        tx_min_frag,
   output logic [7:0]        rx_min_frag,
   output logic              irq
);

   localparam int MS_W = $clog2(MAX_VERIFY_MS + 1);

   generate
      if (NUM_TC < 1 || NUM_TC > 16) begin : g_bad_tc
         $error("NUM_TC must be 1..16");
      end
      if (MAX_VERIFY_MS < 1 || MAX_VERIFY_MS > 255) begin : g_bad_ms
         $error("MAX_VERIFY_MS must be 1..255");
      end
   endgenerate

   localparam logic [1:0] A_ENA = 2'd0, A_VER = 2'd1, A_PRE = 2'd2, A_STAT = 2'd3;

   // configuration registers
   logic              tx_en_q, rx_en_q, dis_q;
   logic [7:0]        vt_cfg_q;
   logic [NUM_TC-1:0] mask_q;
   logic [1:0]        frag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en_q  <= 1'b0;
         rx_en_q  <= 1'b0;
         dis_q    <= 1'b0;
         vt_cfg_q <= 8'(VT_RESET);
         mask_q   <= '0;
         frag_q   <= 2'd0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_ENA: begin
               tx_en_q <= reg_wdata[0];
               rx_en_q <= reg_wdata[1];
            end
            A_VER: begin
               dis_q    <= reg_wdata[0];
               vt_cfg_q <= reg_wdata[15:8];
            end
            A_PRE: begin
               mask_q <= reg_wdata[NUM_TC-1:0];
               frag_q <= reg_wdata[17:16];
            end
            default: ;
         endcase
      end
   end

   logic unused_wbits;
   assign unused_wbits = ^reg_wdata[31:18];

   // effective timeout, clamped to 1..MAX_VERIFY_MS
   logic [MS_W-1:0] vt_eff;
   always_comb begin
      if (vt_cfg_q == 8'd0)                   vt_eff = MS_W'(1);
      else if (32'(vt_cfg_q) > MAX_VERIFY_MS) vt_eff = MS_W'(MAX_VERIFY_MS);
      else                                    vt_eff = MS_W'(vt_cfg_q);
   end

   vstate_e vstate;

   fpv_verify_fsm #(
      .CLKS_PER_MS  (CLKS_PER_MS),
      .MS_W         (MS_W),
      .VERIFY_TRIES (VERIFY_TRIES)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_en       (tx_en_q),
      .verify_dis  (dis_q),
      .vt_ms       (vt_eff),
      .rsp_rx      (rsp_rx),
      .state_o     (vstate),
      .send_verify (send_verify)
   );

   // preemption active flag and its change detector
   logic act, act_q;
   assign act = tx_en_q && (vstate == VS_OK || vstate == VS_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act;
   end

   logic [NUM_EV-1:0] ev_set, ev_clr, sticky;
   always_comb begin
      ev_set         = '0;
      ev_set[EV_ACT] = act ^ act_q;
      ev_set[EV_RX]  = pfrm_rx && (vstate != VS_OK);
      ev_set[EV_TX]  = pfrm_tx_req && !act;
      ev_clr         = (reg_wr && reg_addr == A_STAT) ? reg_wdata[7:5] : '0;
   end

   fpv_sticky_bank #(.N(NUM_EV)) u_sticky (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (ev_set),
      .clr_i    (ev_clr),
      .sticky_o (sticky),
      .irq_o    (irq)
   );

   fpv_tc_gate #(.NUM_TC(NUM_TC), .LINK_GATE(LINK_GATE)) u_gate (
      .active      (act),
      .link_qsgmii (link_qsgmii),
      .link_gig    (link_gig),
      .cfg_mask    (mask_q),
      .commit_mask (commit_tcs)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_ENA: reg_rdata[1:0] = {rx_en_q, tx_en_q};
         A_VER: begin
            reg_rdata[0]    = dis_q;
            reg_rdata[15:8] = vt_cfg_q;
         end
         A_PRE: begin
            reg_rdata[NUM_TC-1:0] = mask_q;
            reg_rdata[17:16]      = frag_q;
         end
         default: begin
            reg_rdata[2:0] = vstate;
            reg_rdata[4]   = act;
            reg_rdata[7:5] = sticky;
         end
      endcase
   end

   assign tx_merge_en = tx_en_q;
   assign rx_merge_en = rx_en_q;
   assign tx_min_frag = tx_frag_bytes(frag_q);
   assign rx_min_frag = 8'(RX_MIN_FRAG);

   // R2: only the five legal state codes
   a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      vstate <= VS_OFF);

   // R6: bypass bit forces the bypass state
   a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dis_q) |-> vstate == VS_OFF);

   // R7: each change of the active flag is latched
   a_r7_act_change: assert property (@(posedge clk) disable iff (!rst_n)
      (act != $past(act)) |=> sticky[EV_ACT]);

   // R11: a nonzero committed mask needs a preemption-capable state
   a_r11_commit_state: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_tcs != '0) |-> (tx_en_q && (vstate == VS_OK || vstate == VS_OFF)));

endmodule

// File: tb/tb_fp_verify_ctrl.sv
`timescale 1ns/1ps
module tb_fp_verify_ctrl;

   localparam int NTC = 4;
   localparam int CPM = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr = 1'b0;
   logic [1:0]     reg_addr = 2'd0;
   logic [31:0]    reg_wdata = '0;
   logic [31:0]    reg_rdata;
   logic           rsp_rx = 1'b0, pfrm_rx = 1'b0, pfrm_tx_req = 1'b0;
   logic           link_gig = 1'b1, link_qsgmii = 1'b0;
   logic           tx_merge_en, rx_merge_en, send_verify, irq;
   logic [NTC-1:0] commit_tcs;
   logic [7:0]     tx_min_frag, rx_min_frag;

   always #5 clk = ~clk;

   fp_verify_ctrl #(.NUM_TC(NTC), .CLKS_PER_MS(CPM)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rsp_rx(rsp_rx),
      .pfrm_rx(pfrm_rx), .pfrm_tx_req(pfrm_tx_req), .link_gig(link_gig),
      .link_qsgmii(link_qsgmii), .tx_merge_en(tx_merge_en),
      .rx_merge_en(rx_merge_en), .send_verify(send_verify),
      .commit_tcs(commit_tcs), .tx_min_frag(tx_min_frag),
      .rx_min_frag(rx_min_frag), .irq(irq)
   );

   int n_chk = 0;
   int n_fail = 0;
   int n_send = 0;
   bit done = 1'b0;

   always @(negedge clk) if (send_verify) n_send++;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // all tasks start and end in the low phase of the clock
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic pulse(input int which);
      case (which)
         0: rsp_rx = 1'b1;
         1: pfrm_rx = 1'b1;
         default: pfrm_tx_req = 1'b1;
      endcase
      @(posedge clk);
      @(negedge clk);
      rsp_rx = 1'b0; pfrm_rx = 1'b0; pfrm_tx_req = 1'b0;
   endtask

   task automatic wait_code(input int code, input string tag);
      logic [31:0] v;
      for (int i = 0; i < 40; i++) begin
         rd(2'd3, v);
         if (int'(v[2:0]) == code) return;
         @(negedge clk);
      end
      check(tag, int'(v[2:0]), code);
   endtask

   function automatic int vt_eff(input int vt);
      if (vt == 0) return 1;
      if (vt > 128) return 128;
      return vt;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired before the sequence completed");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      int vts[4] = '{1, 2, 0, 200};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd3, v);
      check("R1 state code", int'(v[2:0]), 0);
      check("R1 irq", int'(irq), 0);
      check("R1 commit", int'(commit_tcs), 0);
      check("R1 tx enable", int'(tx_merge_en), 0);
      check("R1 rx enable", int'(rx_merge_en), 0);

      // R12 fragment size sweep
      for (int k = 0; k < 4; k++) begin
         wr(2'd2, 32'(k) << 16);
         check("R12 tx min frag", int'(tx_min_frag), 64 * (1 + k) - 4);
      end
      check("R12 rx min frag", int'(rx_min_frag), 60);
      wr(2'd2, 32'd0);

      // R3/R4 handshake failure timing over several timeouts
      foreach (vts[j]) begin
         int n;
         n = 3 * vt_eff(vts[j]) * CPM;
         wr(2'd1, 32'(vts[j]) << 8);
         n_send = 0;
         wr(2'd0, 32'd1);
         wait_code(1, "R3 enter verifying");
         repeat (n - 1) @(negedge clk);
         rd(2'd3, v);
         check("R3/R4 still verifying before last timeout", int'(v[2:0]), 1);
         @(negedge clk);
         rd(2'd3, v);
         check("R3/R4 failed after third timeout", int'(v[2:0]), 3);
         check("R3 verify request count", n_send, 3);
         check("R2 code range", int'(v[2:0] <= 3'd4), 1);
         check("R7 no active change on failure", int'(irq), 0);
         wr(2'd0, 32'd0);
         @(negedge clk);
         rd(2'd3, v);
         check("R3 back to initial", int'(v[2:0]), 0);
      end

      // R5 success via response strobe
      wr(2'd1, 32'd2 << 8);
      wr(2'd0, 32'd3);
      check("R5 rx enable out", int'(rx_merge_en), 1);
      wait_code(1, "R5 enter verifying");
      repeat (3) @(negedge clk);
      pulse(0);
      rd(2'd3, v);
      check("R5 succeeded", int'(v[2:0]), 2);
      check("R5 active", int'(v[4]), 1);
      @(negedge clk);
      rd(2'd3, v);
      check("R7 active-change sticky", int'(v[5]), 1);
      check("R10 irq with sticky", int'(irq), 1);
      wr(2'd3, 32'h20);
      rd(2'd3, v);
      check("R10 w1c clears bit5", int'(v[7:5]), 0);
      check("R10 irq low after clear", int'(irq), 0);

      // R8/R9 frames while allowed leave no trace
      pulse(1);
      pulse(2);
      rd(2'd3, v);
      check("R8 no rx sticky when succeeded", int'(v[6]), 0);
      check("R9 no tx sticky when active", int'(v[7]), 0);
      check("R8/R9 irq stays low", int'(irq), 0);

      // R11 mask gating sweep
      for (int q = 0; q < 2; q++) begin
         for (int g = 0; g < 2; g++) begin
            link_qsgmii = q[0];
            link_gig    = g[0];
            for (int m = 0; m < 16; m++) begin
               wr(2'd2, 32'(m));
               check("R11 committed mask", int'(commit_tcs), (q == 1 && g == 0) ? 0 : m);
            end
         end
      end
      link_qsgmii = 1'b0;
      link_gig    = 1'b1;

      // R7 disabling transmit merge drops active and raises irq
      wr(2'd0, 32'd0);
      check("R11 mask zero when inactive", int'(commit_tcs), 0);
      @(negedge clk);
      rd(2'd3, v);
      check("R7 state initial", int'(v[2:0]), 0);
      check("R7 active low", int'(v[4]), 0);
      check("R7 sticky set", int'(v[5]), 1);
      check("R7 irq", int'(irq), 1);
      wr(2'd3, 32'h20);
      check("R10 irq cleared", int'(irq), 0);

      // R8/R9 unexpected frames while not verified
      pulse(1);
      rd(2'd3, v);
      check("R8 rx sticky", int'(v[6]), 1);
      pulse(2);
      rd(2'd3, v);
      check("R9 tx sticky", int'(v[7]), 1);

      // R10 set and clear collide: set wins
      pfrm_rx = 1'b1;
      wr(2'd3, 32'h40);
      pfrm_rx = 1'b0;
      rd(2'd3, v);
      check("R10 set beats clear", int'(v[6]), 1);
      wr(2'd3, 32'h00);
      rd(2'd3, v);
      check("R10 write zero keeps", int'(v[7:6]), 3);
      wr(2'd3, 32'h40);
      rd(2'd3, v);
      check("R10 rx cleared", int'(v[6]), 0);
      check("R10 irq held by tx bit", int'(irq), 1);
      wr(2'd3, 32'h80);
      check("R10 irq low", int'(irq), 0);

      // R6 verification bypass
      wr(2'd2, 32'h5);
      wr(2'd1, 32'd1 | (32'd2 << 8));
      wr(2'd0, 32'd1);
      @(negedge clk);
      rd(2'd3, v);
      check("R6 disabled code", int'(v[2:0]), 4);
      check("R6 active with tx enabled", int'(v[4]), 1);
      check("R6 mask commits", int'(commit_tcs), 5);
      wr(2'd0, 32'd0);
      rd(2'd3, v);
      check("R6 inactive with tx disabled", int'(v[4]), 0);
      check("R6 still disabled code", int'(v[2:0]), 4);

      done = 1'b1;
      finish_run();
   end

endmodule